// File: doc/BRIEF.md
# Vector Pipe Dispatch Hazard Checker

This block sits at the end of dispatch for the two vector/scalar execution pipes, called VS1 and VS2. In every cycle it looks at up to `NSLOT` candidate operations, oldest first. Each candidate carries a class code and a flag that marks an operation reading four single-precision inputs. For every candidate the block decides whether it dispatches now and which pipe it uses. It also reports which pipes are busy in this cycle.

The class fixes where an operation may go. Vector integer and simple vector (XS) operations run on VS1 only. Permute, select and 128-bit store-data operations run on VS2 only. Scalar and vector floating-point operations may run on either pipe; they try VS1 first and fall back to VS2.

Two cross-pipe hazards are enforced:
- A four-input single-precision operation on VS1 keeps floating point off VS2 in the same cycle.
- XS results and vector floating-point results share one VS1 write-back port. A short history register therefore remembers each vector floating-point dispatch to VS1, and an XS operation is refused exactly `GAP` cycles after such a dispatch.

A refused candidate keeps its grant low and is expected to be presented again unchanged in the following cycles. All younger candidates wait behind it. Grants are combinational from the candidates and the history. The history register is the block's only state: it shifts once per clock and is cleared by reset. There is no state machine.

Top module: `vpipe_dispatch_gate`

## Requirements
- R1: Class 0 (vector integer) and class 1 (XS) are only ever granted on VS1 (pipe bit 0).
- R2: Class 2 (permute/select) and class 3 (store data) are only ever granted on VS2 (pipe bit 1).
- R3: Class 4 (scalar FP) and class 5 (vector FP) take VS1 when it is free and otherwise take VS2 when it is free.
- R4: When the operation granted on VS1 has its quad flag set, no class 4 or 5 operation is granted on VS2 in that cycle. A quad flag on an operation granted on VS2 has no effect.
- R5: A class 1 operation is refused in the cycle exactly `GAP` cycles after a class 5 operation was granted on VS1. It is granted one cycle earlier and one cycle later. Other classes are not affected by this window.
- R6: Each pipe accepts at most one operation per cycle. A later slot that needs a pipe already taken in the same cycle is refused.
- R7: Slots are served in order, slot 0 oldest. A valid slot that is refused blocks every younger slot. Slots without valid are skipped.
- R8: Class codes 6 and 7 are never granted, and they block younger slots under R7.
- R9: Reset clears the dispatch history. With no valid candidate, no grant and no pipe-busy output is raised.
- R10: `vs1_go` and `vs2_go` are high exactly when some slot is granted on VS1 or VS2 respectively.
- R11: The pipe bit of a slot that is not granted reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_valid | input | NSLOT | Candidate present, one bit per slot |
| cand_cls | input | 3*NSLOT | Class code per slot, slot g in bits [3g+2:3g] |
| cand_quad | input | NSLOT | Four single-precision input flag per slot |
| cand_gnt | output | NSLOT | Slot dispatches this cycle |
| cand_pipe | output | NSLOT | Chosen pipe per slot: 0 = VS1, 1 = VS2 |
| vs1_go | output | 1 | VS1 receives an operation this cycle |
| vs2_go | output | 1 | VS2 receives an operation this cycle |

## Verification
The bench builds the block with `NSLOT` = 2 and `GAP` = 5. Two slots are enough to create every pairing that matters here: the two pipes in conflict with each other, an FP operation falling back past an occupied VS1, the quad flag on either side, and an older slot blocking a younger one. A gap of five cycles keeps the write-back window short enough to probe the cycle before it, the cycle itself and the cycle after it. It also allows two back-to-back vector FP dispatches and a reset inside the window.

// File: rtl/vpd_pkg.sv
package vpd_pkg;

    typedef logic [2:0] op_cls_t;

    localparam op_cls_t OP_VINT   = 3'd0;
    localparam op_cls_t OP_XS     = 3'd1;
    localparam op_cls_t OP_PERM   = 3'd2;
    localparam op_cls_t OP_STDATA = 3'd3;
    localparam op_cls_t OP_SFP    = 3'd4;
    localparam op_cls_t OP_VFP    = 3'd5;

    // Pipe usage accumulated along the slot chain within one cycle
    typedef struct packed {
        logic vs1_used;
        logic vs2_used;
        logic vs1_quad;
        logic vs2_fp;
        logic in_order;
    } pipe_occ_t;

endpackage

// File: rtl/vpd_wb_history.sv
module vpd_wb_history #(
    parameter int GAP = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vfp_on_vs1,
    output logic xs_block
);

    localparam int DEPTH = GAP;

    logic [DEPTH-1:0] hist_q;

    // hist_q[k-1] set means a vector FP entered VS1 k cycles ago
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[DEPTH-2:0], vfp_on_vs1};
        end
    end

    assign xs_block = hist_q[DEPTH-1];

    initial begin
        a_r5_gap_range: assert (GAP >= 2);
    end

endmodule

// File: rtl/vpd_slot_steer.sv
module vpd_slot_steer
    import vpd_pkg::*;
(
    input  logic      valid,
    input  op_cls_t   cls,
    input  logic      quad,
    input  logic      xs_block,
    input  pipe_occ_t occ_in,
    output pipe_occ_t occ_out,
    output logic      gnt,
    output logic      pipe,
    output logic      vfp_on_vs1
);

    logic fits_vs1;
    logic fits_vs2;
    logic is_fp;
    logic is_xs;
    logic can_vs1;
    logic can_vs2;
    logic take_vs1;
    logic take_vs2;

    always_comb begin
        fits_vs1 = 1'b0;
        fits_vs2 = 1'b0;
        is_fp    = 1'b0;
        is_xs    = 1'b0;
        unique case (cls)
            OP_VINT:   fits_vs1 = 1'b1;
            OP_XS: begin
                fits_vs1 = 1'b1;
                is_xs    = 1'b1;
            end
            OP_PERM,
            OP_STDATA: fits_vs2 = 1'b1;
            OP_SFP,
            OP_VFP: begin
                fits_vs1 = 1'b1;
                fits_vs2 = 1'b1;
                is_fp    = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        can_vs1  = !occ_in.vs1_used
                   && !(is_xs && xs_block)
                   && !(quad && occ_in.vs2_fp);
        can_vs2  = !occ_in.vs2_used && !(is_fp && occ_in.vs1_quad);
        take_vs1 = valid && occ_in.in_order && fits_vs1 && can_vs1;
        take_vs2 = valid && occ_in.in_order && !take_vs1 && fits_vs2 && can_vs2;
    end

    always_comb begin
        gnt              = take_vs1 || take_vs2;
        pipe             = take_vs2;
        vfp_on_vs1       = take_vs1 && (cls == OP_VFP);
        occ_out.vs1_used = occ_in.vs1_used || take_vs1;
        occ_out.vs2_used = occ_in.vs2_used || take_vs2;
        occ_out.vs1_quad = occ_in.vs1_quad || (take_vs1 && quad);
        occ_out.vs2_fp   = occ_in.vs2_fp || (take_vs2 && is_fp);
        occ_out.in_order = occ_in.in_order && (!valid || gnt);
    end

endmodule

// File: rtl/vpipe_dispatch_gate.sv
module vpipe_dispatch_gate
    import vpd_pkg::*;
#(
    parameter int NSLOT = 2,
    parameter int GAP   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSLOT-1:0]   cand_valid,
    input  logic [3*NSLOT-1:0] cand_cls,
    input  logic [NSLOT-1:0]   cand_quad,
    output logic [NSLOT-1:0]   cand_gnt,
    output logic [NSLOT-1:0]   cand_pipe,
    output logic               vs1_go,
    output logic               vs2_go
);

    localparam int CLS_W = 3;

    pipe_occ_t        occ [NSLOT+1];
    logic [NSLOT-1:0] vfp_vec;
    logic             xs_block;

    assign occ[0] = pipe_occ_t'{in_order: 1'b1, default: 1'b0};

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        vpd_slot_steer u_steer (
            .valid      (cand_valid[g]),
            .cls        (cand_cls[g*CLS_W +: CLS_W]),
            .quad       (cand_quad[g]),
            .xs_block   (xs_block),
            .occ_in     (occ[g]),
            .occ_out    (occ[g+1]),
            .gnt        (cand_gnt[g]),
            .pipe       (cand_pipe[g]),
            .vfp_on_vs1 (vfp_vec[g])
        );

        a_r1_vs1_only: assert property (@(posedge clk) disable iff (!rst_n)
            (cand_gnt[g] && cand_cls[g*CLS_W +: CLS_W] <= OP_XS) |-> !cand_pipe[g]);

        a_r2_vs2_only: assert property (@(posedge clk) disable iff (!rst_n)
            (cand_gnt[g] && (cand_cls[g*CLS_W +: CLS_W] == OP_PERM
                             || cand_cls[g*CLS_W +: CLS_W] == OP_STDATA)) |-> cand_pipe[g]);

        a_r8_undef_refused: assert property (@(posedge clk) disable iff (!rst_n)
            (cand_cls[g*CLS_W +: CLS_W] > OP_VFP) |-> !cand_gnt[g]);

        a_r11_pipe_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !cand_gnt[g] |-> !cand_pipe[g]);

        if (g > 0) begin : g_order
            a_r7_in_order: assert property (@(posedge clk) disable iff (!rst_n)
                cand_gnt[g] |-> &(cand_gnt[g-1:0] | ~cand_valid[g-1:0]));
        end
    end

    vpd_wb_history #(
        .GAP (GAP)
    ) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .vfp_on_vs1 (|vfp_vec),
        .xs_block   (xs_block)
    );

    assign vs1_go = occ[NSLOT].vs1_used;
    assign vs2_go = occ[NSLOT].vs2_used;

    a_r6_one_on_vs1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cand_gnt & ~cand_pipe) <= 1);

    a_r6_one_on_vs2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cand_gnt & cand_pipe) <= 1);

    a_r10_busy_match: assert property (@(posedge clk) disable iff (!rst_n)
        (vs1_go == |(cand_gnt & ~cand_pipe)) && (vs2_go == |(cand_gnt & cand_pipe)));

    a_r4_quad_vs_fp: assert property (@(posedge clk) disable iff (!rst_n)
        !(occ[NSLOT].vs1_quad && occ[NSLOT].vs2_fp));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid == '0) |-> (!vs1_go && !vs2_go && cand_gnt == '0));

endmodule

// File: tb/vpipe_dispatch_gate_bench.sv
module vpipe_dispatch_gate_bench;
    import vpd_pkg::*;

    localparam int NSLOT = 2;
    localparam int GAP   = 5;
    localparam int NV    = 17;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NSLOT-1:0] cand_valid;
    logic [3*NSLOT-1:0] cand_cls;
    logic [NSLOT-1:0] cand_quad;
    logic [NSLOT-1:0] cand_gnt;
    logic [NSLOT-1:0] cand_pipe;
    logic             vs1_go;
    logic             vs2_go;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    vpipe_dispatch_gate #(.NSLOT(NSLOT), .GAP(GAP)) u_vpipe_dispatch_gate (
        .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_cls(cand_cls),
        .cand_quad(cand_quad), .cand_gnt(cand_gnt), .cand_pipe(cand_pipe),
        .vs1_go(vs1_go), .vs2_go(vs2_go)
    );

    // {v0, c0, q0, v1, c1, q1, g0, p0, g1, p1}
    localparam logic [13:0] VEC [NV] = '{
        {1'b1,3'd0,1'b0, 1'b1,3'd2,1'b0, 4'b1011}, // R1 R2
        {1'b1,3'd2,1'b0, 1'b1,3'd0,1'b0, 4'b1110}, // R1 R2
        {1'b1,3'd0,1'b0, 1'b1,3'd1,1'b0, 4'b1000}, // R6 R11
        {1'b1,3'd4,1'b0, 1'b1,3'd4,1'b0, 4'b1011}, // R3
        {1'b1,3'd0,1'b0, 1'b1,3'd5,1'b0, 4'b1011}, // R3
        {1'b1,3'd4,1'b1, 1'b1,3'd4,1'b0, 4'b1000}, // R4
        {1'b1,3'd4,1'b1, 1'b1,3'd2,1'b0, 4'b1011}, // R4
        {1'b1,3'd2,1'b0, 1'b1,3'd4,1'b1, 4'b1110}, // R4
        {1'b1,3'd3,1'b0, 1'b1,3'd3,1'b0, 4'b1100}, // R6
        {1'b0,3'd0,1'b0, 1'b1,3'd0,1'b0, 4'b0010}, // R7
        {1'b1,3'd3,1'b0, 1'b1,3'd1,1'b0, 4'b1110}, // R1 R2
        {1'b1,3'd6,1'b0, 1'b1,3'd0,1'b0, 4'b0000}, // R8 R7
        {1'b1,3'd4,1'b0, 1'b1,3'd0,1'b0, 4'b1000}, // R3 R6
        {1'b1,3'd0,1'b1, 1'b1,3'd4,1'b0, 4'b1000}, // R4
        {1'b1,3'd4,1'b0, 1'b1,3'd5,1'b1, 4'b1011}, // R4
        {1'b1,3'd7,1'b0, 1'b0,3'd0,1'b0, 4'b0000}, // R8
        {1'b1,3'd2,1'b1, 1'b1,3'd4,1'b0, 4'b1110}  // R4
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v0, input logic [2:0] c0, input logic q0,
                         input logic v1, input logic [2:0] c1, input logic q1);
        cand_valid = {v1, v0};
        cand_cls   = {c1, c0};
        cand_quad  = {q1, q0};
    endtask

    task automatic idle();
        drive(1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0);
    endtask

    // Sample 2 ns after the inputs change, well before the next rising edge
    task automatic expect_out(input string tag, input logic g0, input logic p0,
                              input logic g1, input logic p1);
        #2;
        chk({tag, " slot0 grant"}, int'(cand_gnt[0]), int'(g0));
        chk({tag, " slot0 pipe"},  int'(cand_pipe[0]), int'(p0));
        chk({tag, " slot1 grant"}, int'(cand_gnt[1]), int'(g1));
        chk({tag, " slot1 pipe"},  int'(cand_pipe[1]), int'(p1));
        chk({tag, " R10 vs1_go"}, int'(vs1_go), int'((g0 && !p0) || (g1 && !p1)));
        chk({tag, " R10 vs2_go"}, int'(vs2_go), int'((g0 && p0) || (g1 && p1)));
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            idle();
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        idle();
        @(negedge clk);
        @(negedge clk);
        expect_out("R9 reset idle", 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: no entry puts vector FP on VS1, so history stays clear
        for (int i = 0; i < NV; i++) begin
            logic [13:0] e;
            e = VEC[i];
            drive(e[13], e[12:10], e[9], e[8], e[7:5], e[4]);
            expect_out($sformatf("table entry %0d", i), e[3], e[2], e[1], e[0]);
            @(negedge clk);
        end

        // R5: window edges around one vector FP on VS1
        drive(1'b1, OP_VFP, 1'b0, 1'b0, 3'd0, 1'b0);
        expect_out("R5 vfp to vs1", 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        idle_cycles(3);
        drive(1'b1, OP_XS, 1'b0, 1'b0, 3'd0, 1'b0);
        expect_out("R5 xs at gap-1", 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        drive(1'b1, OP_XS, 1'b0, 1'b1, OP_VINT, 1'b0);
        expect_out("R5 xs at gap", 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        drive(1'b1, OP_XS, 1'b0, 1'b0, 3'd0, 1'b0);
        expect_out("R5 xs at gap+1", 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        idle_cycles(GAP + 1);

        // R5: other classes pass inside the window
        drive(1'b1, OP_VFP, 1'b0, 1'b0, 3'd0, 1'b0);
        expect_out("R5 vfp again", 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        idle_cycles(GAP - 1);
        drive(1'b1, OP_VINT, 1'b0, 1'b1, OP_SFP, 1'b0);
        expect_out("R5 vint at gap", 1'b1, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        idle_cycles(GAP + 1);

        // R5: two back-to-back vector FP dispatches widen the refusal
        drive(1'b1, OP_VFP, 1'b0, 1'b0, 3'd0, 1'b0);
        expect_out("R5 vfp first", 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        drive(1'b1, OP_VFP, 1'b0, 1'b0, 3'd0, 1'b0);
        expect_out("R5 vfp second", 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        idle_cycles(GAP - 2);
        drive(1'b1, OP_XS, 1'b0, 1'b0, 3'd0, 1'b0);
        expect_out("R5 held xs t+5", 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        expect_out("R5 held xs t+6", 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        expect_out("R5 held xs t+7", 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        idle_cycles(GAP + 1);

        // R9: reset inside the window clears the history
        drive(1'b1, OP_VFP, 1'b0, 1'b0, 3'd0, 1'b0);
        expect_out("R9 vfp before reset", 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        drive(1'b1, OP_XS, 1'b0, 1'b0, 3'd0, 1'b0);
        expect_out("R9 xs after reset", 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        idle();
        @(negedge clk);

        finish_run();
    end

endmodule